// File: doc/BRIEF.md
# Four-Phase Vertical Transfer Clock Generator

This block produces the timing for moving charge vertically through an area image sensor: four overlapping phase clocks for the image zone, four for the masked storage zone, and the level of the overflow-drain (antiblooming) gate. Each vertical period is cut into eight equal sub-slots. The sub-slot length is set in clock cycles, and during a period the four phases step through a fixed staggered pattern in which every phase stays high for either three or five sub-slots.

A controller pulses `start` with a mode and a period count. In fast-transfer mode, the image and storage phases move together for the requested number of periods, which is how a whole frame is dumped into storage. In this mode the overflow gate drops to its transfer level and is held there for a guard interval before the first period and after the last one. In storage-only mode, only the storage phases move. This is how lines are shifted during readout, and the overflow gate stays at its integration level. `busy` covers the whole sequence and `done` marks its end.

Top module: `vxfer_clkgen`

## Requirements
- R1: After reset, `busy` and `done` are 0, `ab_gate` is 1, and both `img_ph` and `mem_ph` hold the rest pattern 4'b0011: phase 1 (bit 0) and phase 2 (bit 1) high, phases 3 and 4 low.
- R2: A sub-slot lasts `slot_cycles` clock cycles, and a value of 0 acts as 1. A vertical period is eight sub-slots.
- R3: Within a period, sub-slot s drives the pattern {ph4,ph3,ph2,ph1}: 0011 for s=0..2, 1001 for s=3..4, 1100 for s=5, and 0110 for s=6..7. Phases 1/3 and 2/4 are therefore complementary, and phase 2 leads phase 1 by two sub-slots.
- R4: From one clock cycle to the next, at most two lines of `mem_ph` change.
- R5: In fast mode (`mem_only`=0), `img_ph` equals `mem_ph` throughout. The sequence is GUARD_SLOTS sub-slots at rest, then the periods, then GUARD_SLOTS sub-slots at rest.
- R6: In storage-only mode (`mem_only`=1), only `mem_ph` steps through the periods. `img_ph` stays at rest, `ab_gate` stays 1, and no guard sub-slots are inserted.
- R7: `busy` rises in the cycle after `start` is taken and lasts (2·GUARD_SLOTS + 8·N)·L cycles in fast mode, or 8·N·L cycles in storage-only mode. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R8: A pulse count of 0 gives `done` in the cycle after `start`, leaves `busy` low, and leaves every clock line untouched.
- R9: Mode, count and sub-slot length are captured when `start` is taken. Later changes to them, and further `start` pulses while `busy`, have no effect.
- R10: `ab_gate` is 0 for the whole fast sequence. It changes only while both phase groups are at rest, and the image phases leave rest only while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| mem_only | input | 1 | 1 = storage-only shifting, 0 = fast frame transfer |
| pulse_count | input | CNT_W | Number of vertical periods |
| slot_cycles | input | SLOT_W | Sub-slot length in clock cycles (0 treated as 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence marker |
| ab_gate | output | 1 | Overflow gate level: 1 integration, 0 transfer |
| img_ph | output | 4 | Image-zone phases, bit 0 = phase 1 |
| mem_ph | output | 4 | Storage-zone phases, bit 0 = phase 1 |

## Verification
The bench builds the block with CNT_W=11, SLOT_W=4 and GUARD_SLOTS=2. The 11-bit count lets a full 1056-period frame run at the shortest sub-slot. The 4-bit sub-slot field lets the bench cover the zero-as-one case and the largest length of 15. With two guard sub-slots, the guard counter has to wrap, so the pre-guard and post-guard boundaries show up as separate transitions that can be timed against the first and last phase edges.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

   localparam int VX_SLOTS = 8;
   localparam int VX_PHASES = 4;
   localparam logic [3:0] VX_REST = 4'b0011;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_RUN  = 2'd2,
      ST_POST = 2'd3
   } vx_state_e;

   // first sub-slot in which phase p is high
   function automatic int vx_ph_first(input int p);
      case (p)
         0: return 0;
         1: return 6;
         2: return 5;
         default: return 3;
      endcase
   endfunction

   // number of sub-slots phase p stays high
   function automatic int vx_ph_width(input int p);
      return (p < 2) ? 5 : 3;
   endfunction

endpackage

// File: rtl/vxfer_slot_timer.sv
module vxfer_slot_timer #(
   parameter int SLOT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              run,
   input  logic [SLOT_W-1:0] len,
   output logic              slot_end
);
   logic [SLOT_W-1:0] tcnt_q;

   assign slot_end = run && (tcnt_q == len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tcnt_q <= '0;
      else if (clear || slot_end || !run)
         tcnt_q <= '0;
      else
         tcnt_q <= tcnt_q + 1'b1;
   end

   // R2: the cycle counter never passes the programmed length
   assert_slot_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run && !clear && len != '0 |-> tcnt_q < len);
endmodule

// File: rtl/vxfer_phase_gen.sv
module vxfer_phase_gen
   import vxfer_pkg::*;
(
   input  logic [2:0] slot,
   output logic [3:0] pat
);
   for (genvar p = 0; p < VX_PHASES; p++) begin : g_ph
      localparam logic [2:0] FIRST = 3'(vx_ph_first(p));
      localparam logic [3:0] WID   = 4'(vx_ph_width(p));
      logic [2:0] rel;
      assign rel    = slot - FIRST;
      assign pat[p] = ({1'b0, rel} < WID);
   end
endmodule

// File: rtl/vxfer_seq.sv
module vxfer_seq
   import vxfer_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int SLOT_W      = 8,
   parameter int GUARD_SLOTS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mem_only,
   input  logic [CNT_W-1:0]  pulse_count,
   input  logic [SLOT_W-1:0] slot_cycles,
   input  logic              slot_end,
   output logic              accept,
   output logic [SLOT_W-1:0] len,
   output logic              busy,
   output logic              running,
   output logic              fast,
   output logic              done,
   output logic [2:0]        slot
);
   localparam int GW = $clog2(GUARD_SLOTS + 1);
   localparam logic [GW-1:0] GLAST = GW'(GUARD_SLOTS - 1);

   vx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q, per_q;
   logic [GW-1:0]     gcnt_q;
   logic [SLOT_W-1:0] len_q;
   logic              fast_q, done_q;
   logic [2:0]        slot_q;

   assign accept  = (state_q == ST_IDLE) && start && (pulse_count != '0);
   assign len     = len_q;
   assign busy    = (state_q != ST_IDLE);
   assign running = (state_q == ST_RUN);
   assign fast    = fast_q;
   assign done    = done_q;
   assign slot    = slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         per_q   <= '0;
         gcnt_q  <= '0;
         len_q   <= SLOT_W'(1);
         fast_q  <= 1'b0;
         done_q  <= 1'b0;
         slot_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start && pulse_count == '0) begin
                  done_q <= 1'b1;
               end else if (accept) begin
                  cnt_q   <= pulse_count;
                  len_q   <= (slot_cycles == '0) ? SLOT_W'(1) : slot_cycles;
                  fast_q  <= !mem_only;
                  per_q   <= '0;
                  gcnt_q  <= '0;
                  slot_q  <= '0;
                  state_q <= mem_only ? ST_RUN : ST_PRE;
               end
            end
            ST_PRE: begin
               if (slot_end) begin
                  if (gcnt_q == GLAST) begin
                     gcnt_q  <= '0;
                     state_q <= ST_RUN;
                  end else begin
                     gcnt_q <= gcnt_q + 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (slot_end) begin
                  slot_q <= slot_q + 1'b1;
                  if (slot_q == 3'd7) begin
                     if (per_q == cnt_q - 1'b1) begin
                        state_q <= fast_q ? ST_POST : ST_IDLE;
                        done_q  <= !fast_q;
                     end else begin
                        per_q <= per_q + 1'b1;
                     end
                  end
               end
            end
            default: begin
               if (slot_end) begin
                  if (gcnt_q == GLAST) begin
                     gcnt_q  <= '0;
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     gcnt_q <= gcnt_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   // R9: captured settings hold for the whole sequence
   assert_hold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(cnt_q) && $stable(len_q) && $stable(fast_q));
   // R7: done is a single cycle and never overlaps busy
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R5: period counter stays inside the requested count
   assert_period_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> per_q < cnt_q);
endmodule

// File: rtl/vxfer_clkgen.sv
module vxfer_clkgen
   import vxfer_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int SLOT_W      = 8,
   parameter int GUARD_SLOTS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mem_only,
   input  logic [CNT_W-1:0]  pulse_count,
   input  logic [SLOT_W-1:0] slot_cycles,
   output logic              busy,
   output logic              done,
   output logic              ab_gate,
   output logic [3:0]        img_ph,
   output logic [3:0]        mem_ph
);
   if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
      $error("vxfer_clkgen: CNT_W out of range");
   end
   if (SLOT_W < 1 || SLOT_W > 24) begin : g_bad_slot
      $error("vxfer_clkgen: SLOT_W out of range");
   end
   if (GUARD_SLOTS < 1) begin : g_bad_guard
      $error("vxfer_clkgen: GUARD_SLOTS must be at least 1");
   end

   logic              accept, slot_end, running, fast;
   logic [SLOT_W-1:0] len;
   logic [2:0]        slot;
   logic [3:0]        pat;

   vxfer_seq #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .GUARD_SLOTS(GUARD_SLOTS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_only(mem_only),
      .pulse_count(pulse_count), .slot_cycles(slot_cycles), .slot_end(slot_end),
      .accept(accept), .len(len), .busy(busy), .running(running), .fast(fast),
      .done(done), .slot(slot)
   );

   vxfer_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy), .len(len),
      .slot_end(slot_end)
   );

   vxfer_phase_gen u_phase (.slot(slot), .pat(pat));

   assign mem_ph  = running ? pat : VX_REST;
   assign img_ph  = (running && fast) ? pat : VX_REST;
   assign ab_gate = !(busy && fast);

   // R1: outside a sequence everything sits at rest
   assert_rest_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> img_ph == VX_REST && mem_ph == VX_REST && ab_gate);
   // R4: staggered overlap, never more than two lines move at once
   assert_two_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mem_ph ^ $past(mem_ph)) <= 2);
   // R10: image phases leave rest only while the gate is at transfer level
   assert_ab_interlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
      img_ph != VX_REST |-> !ab_gate);
   assert_ab_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ab_gate != $past(ab_gate) |-> img_ph == VX_REST && mem_ph == VX_REST);
   // R6: storage-only shifting never touches the overflow gate
   assert_memonly_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ph != img_ph |-> ab_gate);
endmodule

// File: tb/vxfer_clkgen_bench.sv
module vxfer_clkgen_bench;
   localparam int CNT_W = 11;
   localparam int SLOT_W = 4;
   localparam int G = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic mem_only = 1'b0;
   logic [CNT_W-1:0] pulse_count = '0;
   logic [SLOT_W-1:0] slot_cycles = '0;
   logic busy, done, ab_gate;
   logic [3:0] img_ph, mem_ph;

   int checks = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   vxfer_clkgen #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .GUARD_SLOTS(G)) u_vxfer_clkgen (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_only(mem_only),
      .pulse_count(pulse_count), .slot_cycles(slot_cycles), .busy(busy),
      .done(done), .ab_gate(ab_gate), .img_ph(img_ph), .mem_ph(mem_ph)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // expected {ph4,ph3,ph2,ph1} for sub-slot s (R3)
   function automatic logic [3:0] exp_pat(input int s);
      case (s)
         0, 1, 2: return 4'b0011;
         3, 4:    return 4'b1001;
         5:       return 4'b1100;
         default: return 4'b0110;
      endcase
   endfunction

   task automatic run_case(input bit mo, input int n, input int sc, input bit poke, input string req);
      int l = (sc == 0) ? 1 : sc;
      int t = (n == 0) ? 0 : (mo ? 8 * n * l : 2 * G * l + 8 * n * l);
      logic [3:0] prev = 4'b0011;
      @(negedge clk);
      start = 1'b1; mem_only = mo; pulse_count = CNT_W'(n); slot_cycles = SLOT_W'(sc);
      @(negedge clk);
      start = 1'b0; mem_only = !mo;
      pulse_count = CNT_W'(n + 5); slot_cycles = SLOT_W'(sc + 3);
      for (int k = 0; k <= t + 1; k++) begin
         logic [3:0] ei, em;
         logic ea;
         ei = 4'b0011; em = 4'b0011; ea = 1'b1;
         if (k < t) begin
            if (mo) begin
               em = exp_pat((k / l) % 8);
            end else begin
               ea = 1'b0;
               if (k >= G * l && k < G * l + 8 * n * l) begin
                  em = exp_pat(((k - G * l) / l) % 8);
                  ei = em;
               end
            end
         end
         check(req, "busy (R7)", busy, k < t);
         check(req, "done (R7)", done, k == t);
         check(req, "mem_ph (R3)", mem_ph, em);
         check(req, mo ? "img_ph rest (R6)" : "img_ph follows (R5)", img_ph, ei);
         check(req, "ab_gate (R10)", ab_gate, ea);
         check("R4", "edge count", $countones(mem_ph ^ prev) <= 2, 1);
         prev = mem_ph;
         if (poke && k == 3) begin
            start = 1'b1; pulse_count = CNT_W'(1); mem_only = 1'b1;
         end
         if (poke && k == 4) start = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic test_reset();
      check("R1", "busy", busy, 0);
      check("R1", "done", done, 0);
      check("R1", "ab_gate", ab_gate, 1);
      check("R1", "img_ph", img_ph, 4'b0011);
      check("R1", "mem_ph", mem_ph, 4'b0011);
   endtask

   task automatic test_zero();
      // R8: zero periods finish at once with no clock activity
      run_case(1'b0, 0, 2, 1'b0, "R8");
      run_case(1'b1, 0, 2, 1'b0, "R8");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_case(1'b0, 3, 2, 1'b0, "R5");
      run_case(1'b0, 1, 0, 1'b0, "R2");
      run_case(1'b1, 2, 3, 1'b0, "R6");
      test_zero();
      run_case(1'b0, 2, 1, 1'b1, "R9");
      run_case(1'b1, 1, 15, 1'b0, "R2");
      run_case(1'b0, 1056, 1, 1'b0, "R7");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
         end
      end
   end
endmodule